// File: doc/BRIEF.md
# Paged External Memory Map Decoder

This block sits on the external bus of an 8051-style controller. It turns each 16-bit access into one chip select: a 32K mask ROM, a 32K SRAM, a 256-byte peripheral window or a 128K flash split into four 32K pages. It also drives the two flash page bits and a write enable that is gated by per-page write protection. A write to a protected page raises a one-cycle `wr_blocked` pulse instead of a write enable.

Three configuration pins set the map.

- `mode_app` chooses between two modes:
  - **Development** (`mode_app` = 0): ROM holds program memory.
  - **Application** (`mode_app` = 1): a write-protected flash page holds program memory.
- `page_cfg` picks the flash pages and the protection of the upper page.

The lower half of the address space keeps program and data apart. In the upper half (8000–FFFF), program fetches and data accesses reach the same flash page. In application mode, fetches from 7E00–7EFF go to SRAM, so code placed there can keep running while flash is busy.

A two-state bus machine follows each access:

- **States**:
  - `ST_IDLE`: no strobe is asserted.
  - `ST_ACCESS`: a strobe has been held for one or more cycles.
- **Transitions**:
  - START: `ST_IDLE` to `ST_ACCESS` on the first strobe cycle.
  - HOLD: `ST_ACCESS` to `ST_ACCESS` while a strobe stays asserted.
  - END: `ST_ACCESS` to `ST_IDLE` when all strobes drop.
  - REST: `ST_IDLE` to `ST_IDLE` while the bus stays quiet.

The configuration pins are captured only in cycles with no strobe. The blocked-write pulse is produced only on the START transition.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises with no strobe asserted, every select, `flash_page`, `wr_en` and `wr_blocked` reads 0.
- R2: A data access (`bus_rd` or `bus_wr`, with `bus_fetch` low) to 0000–7EFF selects only `sel_ram`, in both modes.
- R3: A data access to 7F00–7FFF selects only `sel_io`, in both modes.
- R4: In development mode, a fetch (`bus_fetch` = 1) from 0000–7FFF selects only `sel_rom`, and `wr_en` stays 0.
- R5: In development mode, any access to 8000–FFFF selects `sel_flash` with `flash_page` = `page_cfg`. That page is never write protected.
- R6: In application mode, a fetch from 0000–7FFF outside 7E00–7EFF selects `sel_flash` with `flash_page` = {`page_cfg[1]`, 0}.
- R7: In application mode, 8000–FFFF selects `sel_flash` with `flash_page` = {`page_cfg[1]`, 1}. That page is write protected exactly when `page_cfg[0]` = 1.
- R8: In application mode, a fetch from 7E00–7EFF selects `sel_ram`.
- R9: A data write to a protected flash page keeps `wr_en` at 0 and raises `wr_blocked` for exactly one cycle, on the first cycle of the access. A write to an unprotected target drives `wr_en` = 1 for as long as the write strobe is held.
- R10: At most one select is 1 at any time. In the cycle after a sample with no strobe, all selects, `flash_page`, `wr_en` and `wr_blocked` are 0.
- R11: The outputs are registered. They reflect the strobe, address and configuration sampled at the previous rising clock edge.
- R12: The configuration pins are captured only at edges where no strobe is asserted. A change on them while a strobe is held leaves the outputs of that access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Access address |
| bus_fetch | input | 1 | Program fetch strobe; takes precedence over data strobes |
| bus_rd | input | 1 | Data read strobe |
| bus_wr | input | 1 | Data write strobe |
| mode_app | input | 1 | 1 = application mode, 0 = development mode |
| page_cfg | input | 2 | Page and protection configuration; bit 1 is the page-pair bit |
| sel_rom | output | 1 | ROM chip select |
| sel_ram | output | 1 | SRAM chip select |
| sel_io | output | 1 | Peripheral window select |
| sel_flash | output | 1 | Flash chip select |
| flash_page | output | 2 | Flash page number, 0 when flash is not selected |
| wr_en | output | 1 | Write enable after protection gating |
| wr_blocked | output | 1 | One-cycle pulse on a blocked write |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the peripheral window at page 7F and the executable SRAM window at page 7E. This is small enough to sweep all eight configuration-pin combinations against all three access kinds. The sweep uses one address in every 256-byte page plus the edges at 7DFF, 7E00, 7EFF, 7F00, 7FFF, 8000 and FFFF. Each access is held for a second cycle while the configuration pins are inverted. This exposes any capture during an access, and it also shows that the blocked pulse does not repeat.

// File: rtl/memmap_pkg.sv
`timescale 1ns/1ps
package memmap_pkg;

    localparam int PAGE_W = 2;

    typedef enum logic [2:0] {
        T_NONE   = 3'd0,
        T_ROM    = 3'd1,
        T_RAM    = 3'd2,
        T_PERIPH = 3'd3,
        T_FLASH  = 3'd4
    } tgt_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic              app;
        logic [PAGE_W-1:0] sel;
    } cfg_t;

    typedef struct packed {
        tgt_e              tgt;
        logic [PAGE_W-1:0] page;
        logic              prot;
        logic              is_wr;
    } decode_t;

endpackage

// File: rtl/cfg_latch.sv
`timescale 1ns/1ps
module cfg_latch
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_any,
    input  logic              mode_pin,
    input  logic [PAGE_W-1:0] page_pins,
    output cfg_t              cfg_q
);

    // Capture only while no strobe is asserted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!bus_any) begin
            cfg_q.app <= mode_pin;
            cfg_q.sel <= page_pins;
        end
    end

    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_any |=> $stable(cfg_q));

endmodule

// File: rtl/addr_decode.sv
`timescale 1ns/1ps
module addr_decode
    import memmap_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter logic [7:0] IO_PAGE   = 8'h7F,
    parameter logic [7:0] XRAM_PAGE = 8'h7E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic              rd,
    input  logic              wr,
    input  cfg_t              cfg,
    output decode_t           dec
);

    localparam int TOP = ADDR_W - 1;

    logic       upper;
    logic [7:0] hi_byte;
    logic       data_acc;

    assign upper    = addr[TOP];
    assign hi_byte  = addr[TOP -: 8];
    assign data_acc = !fetch && (rd || wr);

    always_comb begin
        dec       = '0;
        dec.tgt   = T_NONE;
        dec.is_wr = wr && !fetch;
        if (fetch || data_acc) begin
            if (upper) begin
                dec.tgt  = T_FLASH;
                dec.page = cfg.app ? {cfg.sel[1], 1'b1} : cfg.sel;
                dec.prot = cfg.app && cfg.sel[0];
            end else if (fetch) begin
                if (!cfg.app) begin
                    dec.tgt = T_ROM;
                end else if (hi_byte == XRAM_PAGE) begin
                    dec.tgt = T_RAM;
                end else begin
                    dec.tgt  = T_FLASH;
                    dec.page = {cfg.sel[1], 1'b0};
                    dec.prot = 1'b1;
                end
            end else if (hi_byte == IO_PAGE) begin
                dec.tgt = T_PERIPH;
            end else begin
                dec.tgt = T_RAM;
            end
        end
    end

endmodule

// File: rtl/bus_fsm.sv
`timescale 1ns/1ps
module bus_fsm
    import memmap_pkg::*;
#(
    parameter int N_TGT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_any,
    input  decode_t           dec,
    output logic [N_TGT-1:0]  sel_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              we_q,
    output logic              blk_q
);

    bus_state_e         state, state_nxt;
    logic [N_TGT-1:0]   sel_d;

    // One select line per target code, codes 1..N_TGT
    for (genvar g = 0; g < N_TGT; g++) begin : g_sel
        assign sel_d[g] = (dec.tgt == tgt_e'(3'(g + 1)));
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = bus_any ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_nxt = bus_any ? ST_ACCESS : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            page_q <= '0;
            we_q   <= 1'b0;
            blk_q  <= 1'b0;
        end else begin
            sel_q  <= bus_any ? sel_d : '0;
            page_q <= (bus_any && dec.tgt == T_FLASH) ? dec.page : '0;
            we_q   <= bus_any && dec.is_wr && !dec.prot;
            unique case (state)
                ST_IDLE:   blk_q <= bus_any && dec.is_wr && dec.prot;
                ST_ACCESS: blk_q <= 1'b0;
                default:   blk_q <= 1'b0;
            endcase
        end
    end

    assert_one_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_any |=> (sel_q == '0 && page_q == '0 && !we_q && !blk_q));
    assert_blk_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q |=> !blk_q);
    assert_we_blk_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_q && blk_q));
    assert_rom_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[0] |-> !we_q);

endmodule

// File: rtl/memmap_decoder.sv
`timescale 1ns/1ps
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter logic [7:0] IO_PAGE   = 8'h7F,
    parameter logic [7:0] XRAM_PAGE = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_fetch,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              mode_app,
    input  logic [1:0]        page_cfg,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_io,
    output logic              sel_flash,
    output logic [1:0]        flash_page,
    output logic              wr_en,
    output logic              wr_blocked
);

    localparam int N_TGT = 4;

    logic             bus_any;
    cfg_t             cfg_q;
    decode_t          dec;
    logic [N_TGT-1:0] sel_q;

    assign bus_any = bus_fetch || bus_rd || bus_wr;

    cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_any   (bus_any),
        .mode_pin  (mode_app),
        .page_pins (page_cfg),
        .cfg_q     (cfg_q)
    );

    addr_decode #(
        .ADDR_W    (ADDR_W),
        .IO_PAGE   (IO_PAGE),
        .XRAM_PAGE (XRAM_PAGE)
    ) u_dec (
        .addr  (bus_addr),
        .fetch (bus_fetch),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .cfg   (cfg_q),
        .dec   (dec)
    );

    bus_fsm #(.N_TGT(N_TGT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_any (bus_any),
        .dec     (dec),
        .sel_q   (sel_q),
        .page_q  (flash_page),
        .we_q    (wr_en),
        .blk_q   (wr_blocked)
    );

    assign sel_rom   = sel_q[0];
    assign sel_ram   = sel_q[1];
    assign sel_io    = sel_q[2];
    assign sel_flash = sel_q[3];

endmodule

// File: tb/memmap_decoder_tb.sv
`timescale 1ns/1ps
module memmap_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_fetch = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic        mode_app = 1'b0;
    logic [1:0]  page_cfg = '0;
    logic        sel_rom, sel_ram, sel_io, sel_flash, wr_en, wr_blocked;
    logic [1:0]  flash_page;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    memmap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_fetch(bus_fetch), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .mode_app(mode_app), .page_cfg(page_cfg),
        .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_io(sel_io),
        .sel_flash(sel_flash), .flash_page(flash_page),
        .wr_en(wr_en), .wr_blocked(wr_blocked)
    );

    function automatic logic [7:0] outs();
        return {sel_rom, sel_ram, sel_io, sel_flash, flash_page, wr_en, wr_blocked};
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string rq);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (rom ram io fl pg[1:0] we blk)", rq, act, exp);
        end
    endtask

    // kind: 0 fetch, 1 read, 2 write
    function automatic logic [7:0] model(input bit app, input bit [1:0] pg,
                                         input bit [15:0] a, input int kind,
                                         output string rq);
        bit rom = 0, ram = 0, io = 0, fl = 0, prot = 0, we, blk;
        bit [1:0] page = 0;
        if (a >= 16'h8000) begin
            fl = 1;
            if (app) begin page = {pg[1], 1'b1}; prot = pg[0]; rq = "R7"; end
            else     begin page = pg;            rq = "R5"; end
        end else if (kind == 0) begin
            if (!app)                 begin rom = 1; rq = "R4"; end
            else if (a[15:8] == 8'h7E) begin ram = 1; rq = "R8"; end
            else begin fl = 1; page = {pg[1], 1'b0}; prot = 1; rq = "R6"; end
        end else if (a >= 16'h7F00) begin io = 1;  rq = "R3"; end
        else                         begin ram = 1; rq = "R2"; end
        we  = (kind == 2) && !prot;
        blk = (kind == 2) && prot;
        if (blk) rq = {rq, "/R9"};
        return {rom, ram, io, fl, page, we, blk};
    endfunction

    task automatic access(input bit [2:0] cfg, input bit [15:0] a, input int kind);
        logic [7:0] exp;
        string rq;
        // idle cycle: configuration captured
        @(negedge clk);
        mode_app = cfg[0]; page_cfg = cfg[2:1];
        bus_fetch = 0; bus_rd = 0; bus_wr = 0;
        @(negedge clk);
        bus_addr = a;
        bus_fetch = (kind == 0); bus_rd = (kind == 1); bus_wr = (kind == 2);
        exp = model(cfg[0], cfg[2:1], a, kind, rq);
        @(negedge clk);
        check(outs(), exp, {rq, "/R11"});
        // hold the access with inverted configuration pins
        mode_app = ~cfg[0]; page_cfg = ~cfg[2:1];
        @(negedge clk);
        check(outs(), {exp[7:1], 1'b0}, "R12/R9 hold");
        bus_fetch = 0; bus_rd = 0; bus_wr = 0;
        @(negedge clk);
        check(outs(), 8'h00, "R10 idle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit [15:0] edges [7] = '{16'h7DFF, 16'h7E00, 16'h7EFF, 16'h7F00,
                                 16'h7FFF, 16'h8000, 16'hFFFF};
        repeat (3) @(negedge clk);
        check(outs(), 8'h00, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(outs(), 8'h00, "R1 after reset");
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 3; k++) begin
                for (int i = 0; i < 256; i++) begin
                    access(3'(c), {8'(i), 8'(i * 37 + 5)}, k);
                end
                for (int e = 0; e < 7; e++) begin
                    access(3'(c), edges[e], k);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule